// File: doc/BRIEF.md
# Video Encoder Control Register Interface

This block is the host-facing register file of a composite video encoder. A processor drives a 6-bit address, an 8-bit data bus, an active-low chip select and an active-low write strobe. A write is committed when the write strobe returns high while chip select is still low. The strobe, chip select, address and data are first passed through a two-flop synchroniser into the encoder clock domain. The write is then performed on the detected rising edge of the strobe, using the address and data captured in the same synchroniser stage.

The file holds two control registers and a few horizontal timing registers, and it returns one status register. The first control register carries the automatic-preset flag, the automatic-standard flag and a two-bit output standard code. The second control register carries six mode enables. When automatic standard selection is on, the upper bit of the standard code follows the detected input line count rather than the written value. The read bus is a purely combinational multiplexer driven by the address, so it does not depend on chip select or the write strobe. The decoded mode bits and timing values are brought out as ports for downstream logic.

Top module: `vid_enc_regif`

## Requirements
- R1: Address map with 8-bit registers: 0x00 holds the first control register, 0x01 the second control register, 0x02 to 0x04 the timing registers (read/write, all 8 bits), and 0x05 the read-only status register.
- R2: A write takes effect when wr_n rises while cs_n is low. The new value is visible on rdata and on the mode outputs after the third rising clk edge that follows the wr_n rise, and not before the second.
- R3: A wr_n pulse while cs_n is high changes no register.
- R4: Addresses 0x06 to 0x3F read 0x00. Writes to them, or to the status address 0x05, change no register.
- R5: While rst_n is low, every register is held at its default: first control 0xC0 (bit 7 auto preset = 1, bit 6 auto standard = 1, standard code 00); second control 0x30; timing registers 0x20, 0x30 and 0x40 at addresses 0x02, 0x03 and 0x04.
- R6: std_sel encodes the output standard as 00 NTSC-M, 01 PAL-M, 10 PAL, 11 PAL-N. Bit 0 of std_sel is written bit 4. Bit 1 of std_sel is std_625 when bit 6 is 1, and written bit 5 otherwise. Read-back of bit 5 at 0x00 shows the same effective value.
- R7: In the second control register, bit 0 is free-run, bit 1 black-and-burst, bit 2 blanking-interval pass, bit 3 chroma off, bit 4 luma comb enable and bit 5 sin(x)/x enable; mode_bits[5:0] mirrors bits 5:0. Bits 7:6 of this register and bits 3:0 of the first control register read 0.
- R8: rdata depends only on addr and the register contents. It follows an address change without any clock edge, whatever the levels of cs_n and wr_n.
- R9: The status register reads std_625 in bit 0 and 0 in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, commits on rising edge |
| std_625 | input | 1 | Detected input line standard (1 = 625 lines) |
| rdata | output | 8 | Read data for the addressed register |
| auto_reg | output | 1 | Automatic preset flag |
| auto_std | output | 1 | Automatic standard flag |
| std_sel | output | 2 | Effective output standard code |
| mode_bits | output | 6 | Second control register bits 5:0 |
| tim_flat | output | 24 | Timing registers, register 0 in bits 7:0 |

## Verification
On every cycle, the assertions check four things: that no mode or timing output changes without a commit pulse, that the commit is a single-cycle event, that the upper standard bit tracks the detected line count under automatic selection, and that unused addresses read zero. They also check the defaults on each clock edge while reset is low. Only the bench scenarios can show the rest. These cover the exact latency from the strobe edge to visibility, the rejection of strobes with chip select high, the masking of unused bits, the read-only status register, and read-back that follows address changes while the strobe is held low.

// File: rtl/vid_enc_regif_pkg.sv
package vid_enc_regif_pkg;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_CTL0 = 6'h00;
  localparam logic [AW-1:0] A_CTL1 = 6'h01;
  localparam logic [AW-1:0] A_TIM0 = 6'h02;
  localparam logic [DW-1:0] CTL0_DEF  = 8'hC0;
  localparam logic [DW-1:0] CTL0_MASK = 8'hF0;
  localparam logic [DW-1:0] CTL1_DEF  = 8'h30;
  localparam logic [DW-1:0] CTL1_MASK = 8'h3F;

  // default for timing register idx
  function automatic logic [DW-1:0] tim_default(input int idx);
    return DW'(8'h20 + 8'h10 * idx);
  endfunction

  // first control register as seen downstream and on read-back
  function automatic logic [DW-1:0] ctl0_effective(input logic [DW-1:0] raw,
                                                   input logic det625);
    logic [DW-1:0] v;
    v = raw & CTL0_MASK;
    if (raw[6]) v[5] = det625;
    return v;
  endfunction
endpackage

// File: rtl/vid_enc_wr_sync.sv
module vid_enc_wr_sync
  import vid_enc_regif_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_commit,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wval
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] wr_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [AW-1:0]     a_pipe [STAGES];
  logic [DW-1:0]     d_pipe [STAGES];
  logic              wr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pipe <= '1;
      cs_pipe <= '1;
      wr_last <= 1'b1;
      for (int i = 0; i < STAGES; i++) begin
        a_pipe[i] <= '0;
        d_pipe[i] <= '0;
      end
    end else begin
      wr_pipe[0] <= wr_n;
      cs_pipe[0] <= cs_n;
      a_pipe[0]  <= addr;
      d_pipe[0]  <= wdata;
      for (int i = 1; i < STAGES; i++) begin
        wr_pipe[i] <= wr_pipe[i-1];
        cs_pipe[i] <= cs_pipe[i-1];
        a_pipe[i]  <= a_pipe[i-1];
        d_pipe[i]  <= d_pipe[i-1];
      end
      wr_last <= wr_pipe[LAST];
    end
  end

  assign wr_commit = wr_pipe[LAST] & ~wr_last & ~cs_pipe[LAST];
  assign waddr     = a_pipe[LAST];
  assign wval      = d_pipe[LAST];
endmodule

// File: rtl/vid_enc_reg_bank.sv
module vid_enc_reg_bank
  import vid_enc_regif_pkg::*;
#(
  parameter int N_TIM = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_commit,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wval,
  output logic [DW-1:0]      ctl0_raw,
  output logic [DW-1:0]      ctl1,
  output logic [N_TIM*DW-1:0] tim_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_raw <= CTL0_DEF;
      ctl1     <= CTL1_DEF;
    end else if (wr_commit) begin
      if (waddr == A_CTL0) ctl0_raw <= wval & CTL0_MASK;
      if (waddr == A_CTL1) ctl1     <= wval & CTL1_MASK;
    end
  end

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    localparam logic [AW-1:0] MY_ADDR = AW'(A_TIM0 + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tim_flat[g*DW +: DW] <= tim_default(g);
      else if (wr_commit && waddr == MY_ADDR)
        tim_flat[g*DW +: DW] <= wval;
    end
  end
endmodule

// File: rtl/vid_enc_rd_mux.sv
module vid_enc_rd_mux
  import vid_enc_regif_pkg::*;
#(
  parameter int N_TIM = 3
) (
  input  logic [AW-1:0]       addr,
  input  logic                std_625,
  input  logic [DW-1:0]       ctl0_raw,
  input  logic [DW-1:0]       ctl1,
  input  logic [N_TIM*DW-1:0] tim_flat,
  output logic [DW-1:0]       rdata
);
  localparam int A_STAT = 2 + N_TIM;

  always_comb begin
    rdata = '0;
    if (addr == A_CTL0)
      rdata = ctl0_effective(ctl0_raw, std_625);
    else if (addr == A_CTL1)
      rdata = ctl1;
    else if (int'(addr) == A_STAT)
      rdata = {{(DW-1){1'b0}}, std_625};
    else
      for (int i = 0; i < N_TIM; i++)
        if (int'(addr) == int'(A_TIM0) + i) rdata = tim_flat[i*DW +: DW];
  end
endmodule

// File: rtl/vid_enc_regif.sv
module vid_enc_regif
  import vid_enc_regif_pkg::*;
#(
  parameter int N_TIM       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [5:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               std_625,
  output logic [7:0]         rdata,
  output logic               auto_reg,
  output logic               auto_std,
  output logic [1:0]         std_sel,
  output logic [5:0]         mode_bits,
  output logic [N_TIM*8-1:0] tim_flat
);
  logic          wr_commit;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wval;
  logic [DW-1:0] ctl0_raw;
  logic [DW-1:0] ctl1;
  logic [DW-1:0] ctl0_eff;

  vid_enc_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata),
    .wr_commit(wr_commit), .waddr(waddr), .wval(wval)
  );

  vid_enc_reg_bank #(.N_TIM(N_TIM)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit),
    .waddr(waddr), .wval(wval),
    .ctl0_raw(ctl0_raw), .ctl1(ctl1), .tim_flat(tim_flat)
  );

  vid_enc_rd_mux #(.N_TIM(N_TIM)) u_rd (
    .addr(addr), .std_625(std_625), .ctl0_raw(ctl0_raw),
    .ctl1(ctl1), .tim_flat(tim_flat), .rdata(rdata)
  );

  assign ctl0_eff  = ctl0_effective(ctl0_raw, std_625);
  assign auto_reg  = ctl0_eff[7];
  assign auto_std  = ctl0_eff[6];
  assign std_sel   = ctl0_eff[5:4];
  assign mode_bits = ctl1[5:0];
endmodule

// File: rtl/vid_enc_regif_chk.sv
module vid_enc_regif_chk #(
  parameter int N_TIM = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [5:0]         addr,
  input logic               std_625,
  input logic [7:0]         rdata,
  input logic               auto_reg,
  input logic               auto_std,
  input logic [1:0]         std_sel,
  input logic [5:0]         mode_bits,
  input logic [N_TIM*8-1:0] tim_flat,
  input logic               wr_commit
);
  // R5: defaults held during reset
  always @(posedge clk)
    if (!rst_n)
      p_reset_defaults_r5: assert (auto_reg && auto_std && std_sel[0] == 1'b0
                                   && mode_bits == 6'h30);

  p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R3/R4: state only changes after a commit
  p_no_change_without_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(mode_bits) && $stable(tim_flat) && $stable(auto_reg)
                    && $stable(auto_std) && $stable(std_sel[0])));

  p_auto_std_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_std |-> std_sel[1] == std_625);

  p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 6'h05) |-> rdata == 8'h00);
endmodule

bind vid_enc_regif vid_enc_regif_chk #(.N_TIM(N_TIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .std_625(std_625), .rdata(rdata),
  .auto_reg(auto_reg), .auto_std(auto_std), .std_sel(std_sel),
  .mode_bits(mode_bits), .tim_flat(tim_flat), .wr_commit(wr_commit)
);

// File: tb/vid_enc_regif_bench.sv
`timescale 1ns/1ps
module vid_enc_regif_bench;
  logic clk = 0;
  logic rst_n = 1;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0;
  logic cs_n = 1, wr_n = 1, std_625 = 0;
  logic [7:0] rdata;
  logic auto_reg, auto_std;
  logic [1:0] std_sel;
  logic [5:0] mode_bits;
  logic [23:0] tim_flat;

  int checks = 0, errors = 0;
  int mem [0:63];   // behavioural model of stored values

  always #5 clk = ~clk;

  vid_enc_regif u_vid_enc_regif (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .cs_n(cs_n),
    .wr_n(wr_n), .std_625(std_625), .rdata(rdata), .auto_reg(auto_reg),
    .auto_std(auto_std), .std_sel(std_sel), .mode_bits(mode_bits),
    .tim_flat(tim_flat)
  );

  function automatic int model_read(input int a);
    int v;
    if (a == 0) begin
      v = mem[0];
      if ((v & 8'h40) != 0) v = (v & 8'hDF) | (std_625 ? 8'h20 : 0);
      return v;
    end
    if (a == 5) return std_625 ? 1 : 0;
    if (a >= 1 && a <= 4) return mem[a];
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[0] = 8'hC0; mem[1] = 8'h30;
    mem[2] = 8'h20; mem[3] = 8'h30; mem[4] = 8'h40;
  endtask

  // compare every address plus the mode outputs against the model
  task automatic sweep(input string req);
    int e0;
    for (int a = 0; a < 64; a++) begin
      addr = 6'(a); #1;
      chk(req, rdata, model_read(a));
    end
    e0 = model_read(0);
    chk(req, {auto_reg, auto_std, std_sel}, e0 >> 4);
    chk(req, mode_bits, mem[1] & 8'h3F);
    chk(req, tim_flat, {mem[4][7:0], mem[3][7:0], mem[2][7:0]});
  endtask

  task automatic bus_write(input int a, input int d, input bit sel, input bit upd);
    @(negedge clk);
    addr = 6'(a); wdata = 8'(d); cs_n = !sel;
    @(negedge clk); wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1;
    if (upd && sel) begin
      if (a == 0) mem[0] = d & 8'hF0;
      else if (a == 1) mem[1] = d & 8'h3F;
      else if (a >= 2 && a <= 4) mem[a] = d & 8'hFF;
    end
  endtask

  initial begin
    model_reset();
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    sweep("R5");
    rst_n = 1;
    @(negedge clk);
    sweep("R1");

    // R2: latency of the commit
    @(negedge clk);
    addr = 6'h02; wdata = 8'hA5; cs_n = 0;
    @(negedge clk); wr_n = 0;
    @(negedge clk); @(posedge clk); #1 wr_n = 1;  // rise just after an edge
    @(posedge clk); @(posedge clk); #1;
    chk("R2 early", rdata, 8'h20);
    @(posedge clk); #1;
    chk("R2 commit", rdata, 8'hA5);
    mem[2] = 8'hA5;
    repeat (3) @(negedge clk); cs_n = 1;
    sweep("R2");

    bus_write(3, 8'h5A, 1, 1);   sweep("R1");
    bus_write(4, 8'hFF, 1, 1);   sweep("R1");
    bus_write(3, 8'h11, 0, 0);   sweep("R3");
    bus_write(6'h3F, 8'hFF, 1, 0); sweep("R4");
    bus_write(6'h06, 8'h77, 1, 0); sweep("R4");
    bus_write(5, 8'hFF, 1, 0);   sweep("R9");
    std_625 = 1; #1;             sweep("R9");

    // R7: mode bits, each one alone and all with unused bits
    for (int b = 0; b < 6; b++) begin
      bus_write(1, 1 << b, 1, 1); sweep("R7");
    end
    bus_write(1, 8'hFF, 1, 1);   sweep("R7");
    bus_write(0, 8'hFF, 1, 1);   sweep("R7");

    // R6: manual standard codes, then auto following detection
    for (int s = 0; s < 4; s++) begin
      bus_write(0, 8'h80 | (s << 4), 1, 1);
      std_625 = s[0]; #1;
      sweep("R6");
      chk("R6 std_sel", std_sel, s);
    end
    bus_write(0, 8'h50, 1, 1);
    std_625 = 0; #1; sweep("R6");
    chk("R6 auto", std_sel, 2'b01);
    std_625 = 1; #1; sweep("R6");
    chk("R6 auto", std_sel, 2'b11);

    // R8: read mux with strobe held low and chip select low
    @(negedge clk); cs_n = 1; wr_n = 0;
    addr = 6'h04; #1 chk("R8", rdata, mem[4]);
    addr = 6'h01; #1 chk("R8", rdata, mem[1]);
    cs_n = 0; addr = 6'h03; #1 chk("R8", rdata, mem[3]);
    addr = 6'h20; #1 chk("R8", rdata, 0);
    cs_n = 1; #1; wr_n = 1;   // rise with cs_n high: no write
    repeat (4) @(negedge clk);
    sweep("R3");

    // R5: reset again restores defaults
    rst_n = 0; model_reset(); #1;
    sweep("R5");
    rst_n = 1;
    @(negedge clk);
    sweep("R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule